// File: doc/BRIEF.md
# Scaled-Index Effective Address Unit

This block forms a 32-bit memory address from up to three terms: a base register, an index register shifted left by a scale, and a displacement carried in the instruction. Each term can be switched off on its own, so one datapath serves every usual addressing form. The supported forms are a bare displacement (direct), a bare base (register indirect), base plus displacement, scaled index plus displacement, and the full base plus scaled index plus displacement. The sum wraps modulo 2^32 and gives no overflow indication.

The unit reads base and index from a snapshot of an eight-entry, 32-bit register file that arrives as one flat input vector. Entry k occupies bits [32k+31:32k]. A request carries enable bits for base and index, two 3-bit register selectors, a 2-bit scale code, a displacement field and a 2-bit displacement size code. By default one output register stage adds a single cycle of latency. The result's valid bit follows the request valid through that stage. Entry 4 serves as the stack pointer. It can be used as a base, but selecting it as the index means there is no index.

Top module: `eff_addr_unit`

## Requirements
- R1: While rst_n is low, ea_valid and ea_out are both zero.
- R2: With the default output stage, ea_valid in a cycle equals in_valid one clock edge earlier, and ea_out carries the address of that request.
- R3: The three terms are added modulo 2^32; a carry out of bit 31 is dropped, with no other output.
- R4: The scale code multiplies the index: 2'b00 by 1, 2'b01 by 2, 2'b10 by 4, 2'b11 by 8, applied as a left shift whose lost upper bits are discarded.
- R5: Displacement size code 2'b00 means no displacement. 2'b01 sign-extends disp_field[7:0], 2'b10 sign-extends disp_field[15:0], and 2'b11 uses all of disp_field. Field bits above the selected size have no effect.
- R6: When use_base is low, the base term is zero, whatever base_sel names.
- R7: When use_index is low, or index_sel is 4, the index term is zero, whatever the scale code.
- R8: Any of the eight entries, including entry 4, can serve as the base. Selector value k reads rf_flat[32k+31:32k].
- R9: A cycle with in_valid low leaves ea_out at its last value, even if the register file changes, and drives ea_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| use_base | input | 1 | Include the base term |
| base_sel | input | 3 | Base register selector |
| use_index | input | 1 | Include the scaled index term |
| index_sel | input | 3 | Index register selector (4 means none) |
| scale_code | input | 2 | Index scale: 1, 2, 4 or 8 |
| disp_size | input | 2 | Displacement size code |
| disp_field | input | 32 | Raw displacement bits |
| rf_flat | input | 256 | Eight 32-bit register values, entry k in bits [32k+31:32k] |
| ea_out | output | 32 | Effective address |
| ea_valid | output | 1 | ea_out holds a new result |

## Verification
Every result is due exactly one clock edge after its request is applied. The driver applies a request on a falling edge and pushes the expected item, and the monitor pops that item just after the next rising edge. Idle cycles push an item that expects valid low and the previous address, so the scoreboard checks hold behaviour on the same one-edge schedule. Register file changes are applied only in idle cycles, never between a request and its result.

// File: rtl/eau_pkg.sv
package eau_pkg;

    localparam int EAU_AW    = 32;
    localparam int EAU_NREG  = 8;
    localparam int EAU_SELW  = $clog2(EAU_NREG);
    localparam int EAU_SP    = 4;

    typedef enum logic [1:0] {
        DSZ_NONE = 2'b00,
        DSZ_B8   = 2'b01,
        DSZ_B16  = 2'b10,
        DSZ_FULL = 2'b11
    } disp_size_e;

    typedef enum logic [1:0] {
        SCL_X1 = 2'b00,
        SCL_X2 = 2'b01,
        SCL_X4 = 2'b10,
        SCL_X8 = 2'b11
    } scale_e;

endpackage

// File: rtl/eau_reg_read.sv
// Selects one register value from the flattened file, or zero when disabled.
module eau_reg_read #(
    parameter int AW   = 32,
    parameter int NREG = 8,
    parameter int SELW = $clog2(NREG)
) (
    input  logic [AW*NREG-1:0] rf_flat,
    input  logic [SELW-1:0]    sel,
    input  logic               enable,
    output logic [AW-1:0]      value
);

    logic [AW-1:0] entry [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_entry
        assign entry[k] = rf_flat[AW*k +: AW];
    end

    always_comb begin
        value = '0;
        if (enable) begin
            value = entry[sel];
        end
    end

endmodule

// File: rtl/eau_scaler.sv
// Multiplies the index by 1, 2, 4 or 8 through a left shift.
module eau_scaler #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] index_in,
    input  logic [1:0]    scale_code,
    output logic [AW-1:0] index_out
);
    import eau_pkg::*;

    always_comb begin
        unique case (scale_e'(scale_code))
            SCL_X1:  index_out = index_in;
            SCL_X2:  index_out = {index_in[AW-2:0], 1'b0};
            SCL_X4:  index_out = {index_in[AW-3:0], 2'b00};
            SCL_X8:  index_out = {index_in[AW-4:0], 3'b000};
            default: index_out = index_in;
        endcase
    end

endmodule

// File: rtl/eau_disp_ext.sv
// Widens the displacement to the address width per its size code.
module eau_disp_ext #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] disp_field,
    input  logic [1:0]    disp_size,
    output logic [AW-1:0] disp_out
);
    import eau_pkg::*;

    always_comb begin
        unique case (disp_size_e'(disp_size))
            DSZ_NONE: disp_out = '0;
            DSZ_B8:   disp_out = {{(AW-8){disp_field[7]}}, disp_field[7:0]};
            DSZ_B16:  disp_out = {{(AW-16){disp_field[15]}}, disp_field[15:0]};
            DSZ_FULL: disp_out = disp_field;
            default:  disp_out = '0;
        endcase
    end

endmodule

// File: rtl/eff_addr_unit.sv
// Effective address unit: base + (index << scale) + displacement.
module eff_addr_unit #(
    parameter int AW      = eau_pkg::EAU_AW,
    parameter int NREG    = eau_pkg::EAU_NREG,
    parameter int SP_IDX  = eau_pkg::EAU_SP,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 use_base,
    input  logic [2:0]           base_sel,
    input  logic                 use_index,
    input  logic [2:0]           index_sel,
    input  logic [1:0]           scale_code,
    input  logic [1:0]           disp_size,
    input  logic [AW-1:0]        disp_field,
    input  logic [AW*NREG-1:0]   rf_flat,
    output logic [AW-1:0]        ea_out,
    output logic                 ea_valid
);

    localparam int SELW = $clog2(NREG);

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
    } stage_t;

    logic [AW-1:0] base_term;
    logic [AW-1:0] index_raw;
    logic [AW-1:0] index_term;
    logic [AW-1:0] disp_term;
    logic [AW-1:0] sum;
    logic          index_on;

    assign index_on = use_index && (index_sel != SELW'(SP_IDX));

    eau_reg_read #(.AW(AW), .NREG(NREG), .SELW(SELW)) u_base_rd (
        .rf_flat (rf_flat),
        .sel     (base_sel),
        .enable  (use_base),
        .value   (base_term)
    );

    eau_reg_read #(.AW(AW), .NREG(NREG), .SELW(SELW)) u_index_rd (
        .rf_flat (rf_flat),
        .sel     (index_sel),
        .enable  (index_on),
        .value   (index_raw)
    );

    eau_scaler #(.AW(AW)) u_scaler (
        .index_in   (index_raw),
        .scale_code (scale_code),
        .index_out  (index_term)
    );

    eau_disp_ext #(.AW(AW)) u_disp (
        .disp_field (disp_field),
        .disp_size  (disp_size),
        .disp_out   (disp_term)
    );

    // Carry out of the top bit is dropped: modular sum.
    assign sum = base_term + index_term + disp_term;

    if (OUT_REG) begin : g_reg
        stage_t stage_d;
        stage_t stage_q;

        always_comb begin
            stage_d       = stage_q;
            stage_d.valid = in_valid;
            if (in_valid) begin
                stage_d.addr = sum;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q <= '0;
            end else begin
                stage_q <= stage_d;
            end
        end

        assign ea_out   = stage_q.addr;
        assign ea_valid = stage_q.valid;
    end else begin : g_comb
        assign ea_out   = sum;
        assign ea_valid = in_valid;
    end

endmodule

// File: rtl/eau_checker.sv
// Temporal properties of the effective address unit.
module eau_checker #(
    parameter int AW      = 32,
    parameter int NREG    = 8,
    parameter int SP_IDX  = 4,
    parameter bit OUT_REG = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               use_base,
    input logic [2:0]         base_sel,
    input logic               use_index,
    input logic [2:0]         index_sel,
    input logic [1:0]         disp_size,
    input logic [AW*NREG-1:0] rf_flat,
    input logic [AW-1:0]      ea_out,
    input logic               ea_valid
);

    logic no_index;
    logic [AW-1:0] base_val;

    assign no_index = !use_index || (index_sel == 3'(SP_IDX));
    assign base_val = rf_flat[AW*base_sel +: AW];

    if (OUT_REG) begin : g_seq
        p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (ea_valid == $past(in_valid)));

        p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(ea_out) && !ea_valid));

        p_no_terms_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !use_base && no_index && disp_size == 2'b00)
            |=> (ea_out == '0));

        p_sp_not_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !use_base && use_index && index_sel == 3'(SP_IDX)
             && disp_size == 2'b00) |=> (ea_out == '0));

        p_base_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && use_base && no_index && disp_size == 2'b00)
            |=> (ea_out == $past(base_val)));
    end

endmodule

bind eff_addr_unit eau_checker #(
    .AW(AW), .NREG(NREG), .SP_IDX(SP_IDX), .OUT_REG(OUT_REG)
) u_eau_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .use_base  (use_base),
    .base_sel  (base_sel),
    .use_index (use_index),
    .index_sel (index_sel),
    .disp_size (disp_size),
    .rf_flat   (rf_flat),
    .ea_out    (ea_out),
    .ea_valid  (ea_valid)
);

// File: tb/eff_addr_unit_bench.sv
module eff_addr_unit_bench;

    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         use_base = 1'b0;
    logic [2:0]   base_sel = '0;
    logic         use_index = 1'b0;
    logic [2:0]   index_sel = '0;
    logic [1:0]   scale_code = '0;
    logic [1:0]   disp_size = '0;
    logic [31:0]  disp_field = '0;
    logic [255:0] rf_flat = '0;
    logic [31:0]  ea_out;
    logic         ea_valid;

    logic [31:0]  rf_m [8];
    logic [32:0]  q_exp [$];
    string        q_tag [$];
    logic [31:0]  last_addr = '0;
    int           total = 0;
    int           bad = 0;
    bit           finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    eff_addr_unit u_eff_addr_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .use_base(use_base), .base_sel(base_sel),
        .use_index(use_index), .index_sel(index_sel),
        .scale_code(scale_code), .disp_size(disp_size),
        .disp_field(disp_field), .rf_flat(rf_flat),
        .ea_out(ea_out), .ea_valid(ea_valid)
    );

    function automatic logic [31:0] model(input logic ub, input logic [2:0] bs,
                                          input logic ui, input logic [2:0] is,
                                          input logic [1:0] sc, input logic [1:0] ds,
                                          input logic [31:0] df);
        logic [31:0] b, x, d;
        b = ub ? rf_m[bs] : 32'h0;
        x = (ui && is != 3'd4) ? (rf_m[is] << sc) : 32'h0;
        case (ds)
            2'b01:   d = {{24{df[7]}}, df[7:0]};
            2'b10:   d = {{16{df[15]}}, df[15:0]};
            2'b11:   d = df;
            default: d = 32'h0;
        endcase
        return b + x + d;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic ub, input logic [2:0] bs, input logic ui,
                        input logic [2:0] is, input logic [1:0] sc,
                        input logic [1:0] ds, input logic [31:0] df, input string tag);
        @(negedge clk);
        in_valid = 1'b1; use_base = ub; base_sel = bs; use_index = ui;
        index_sel = is; scale_code = sc; disp_size = ds; disp_field = df;
        last_addr = model(ub, bs, ui, is, sc, ds, df);
        q_exp.push_back({1'b1, last_addr});
        q_tag.push_back(tag);
    endtask

    // Idle cycle; optionally reloads the register file (R9: must not disturb ea_out).
    task automatic idle(input string tag, input bit reload, input logic [31:0] seed);
        @(negedge clk);
        in_valid = 1'b0; use_base = 1'b1; base_sel = 3'd1;
        use_index = 1'b1; index_sel = 3'd2; disp_size = 2'b11; disp_field = 32'h1234;
        if (reload) begin
            for (int k = 0; k < 8; k++) begin
                rf_m[k] = seed * (k + 3) ^ (32'h0101_0101 << k);
                rf_flat[32*k +: 32] = rf_m[k];
            end
        end
        q_exp.push_back({1'b0, last_addr});
        q_tag.push_back(tag);
    endtask

    // Monitor: each item is due one rising edge after it was driven.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && q_exp.size() != 0) begin
                logic [32:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                check({t, " valid"}, {31'h0, ea_valid}, {31'h0, e[32]});
                check({t, " addr"}, ea_out, e[31:0]);
            end
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) begin
            rf_m[k] = 32'h1000_0000 * k + 32'h0000_0100 * (k + 1);
            rf_flat[32*k +: 32] = rf_m[k];
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset valid", {31'h0, ea_valid}, 32'h0);
        check("R1 reset addr", ea_out, 32'h0);
        rst_n = 1'b1;

        // R8: every entry as base, including entry 4
        for (int k = 0; k < 8; k++) begin
            send(1'b1, 3'(k), 1'b0, 3'd0, 2'b00, 2'b00, 32'h0, "R8 base only");
        end
        // R4: each scale on index 3, no base
        for (int s = 0; s < 4; s++) begin
            send(1'b0, 3'd0, 1'b1, 3'd3, 2'(s), 2'b00, 32'h0, "R4 scaled index");
        end
        // R5: displacement sizes with junk in unused upper bits
        send(1'b0, 3'd0, 1'b0, 3'd0, 2'b01, 2'b01, 32'hABCD_EF80, "R5 disp8 negative");
        send(1'b0, 3'd0, 1'b0, 3'd0, 2'b01, 2'b01, 32'hFFFF_FF7F, "R5 disp8 positive");
        send(1'b0, 3'd0, 1'b0, 3'd0, 2'b00, 2'b10, 32'h5555_8001, "R5 disp16 negative");
        send(1'b0, 3'd0, 1'b0, 3'd0, 2'b00, 2'b10, 32'hAAAA_7FFE, "R5 disp16 positive");
        send(1'b0, 3'd0, 1'b0, 3'd0, 2'b00, 2'b11, 32'h8765_4321, "R5 disp32");
        send(1'b0, 3'd0, 1'b0, 3'd0, 2'b00, 2'b00, 32'hFFFF_FFFF, "R5 disp none");
        // R6: base disabled, selector pointing at nonzero entry
        send(1'b0, 3'd5, 1'b1, 3'd1, 2'b10, 2'b01, 32'h0000_0010, "R6 no base");
        // R7: index 4 or index disabled
        send(1'b1, 3'd2, 1'b1, 3'd4, 2'b11, 2'b00, 32'h0, "R7 sp as index");
        send(1'b1, 3'd2, 1'b0, 3'd6, 2'b11, 2'b10, 32'h0000_0040, "R7 index off");
        // full form
        send(1'b1, 3'd4, 1'b1, 3'd7, 2'b01, 2'b11, 32'h0000_1000, "R2 full form");
        idle("R9 idle", 1'b0, 32'h0);
        idle("R9 idle rf reload", 1'b1, 32'h3C3C_0F0F);
        send(1'b1, 3'd6, 1'b1, 3'd5, 2'b11, 2'b10, 32'h0000_F00F, "R2 after reload");
        idle("R9 idle after", 1'b0, 32'h0);

        // R3: wrap around
        @(negedge clk);
        in_valid = 1'b0;
        rf_m[1] = 32'hFFFF_FFF0; rf_flat[32 +: 32] = rf_m[1];
        rf_m[2] = 32'h8000_0001; rf_flat[64 +: 32] = rf_m[2];
        q_exp.push_back({1'b0, last_addr});
        q_tag.push_back("R9 idle");
        send(1'b1, 3'd1, 1'b0, 3'd0, 2'b00, 2'b11, 32'h0000_0020, "R3 wrap base+disp");
        send(1'b0, 3'd0, 1'b1, 3'd2, 2'b01, 2'b00, 32'h0, "R3 wrap scaled");
        idle("R9 idle", 1'b0, 32'h0);
        @(negedge clk);
        check("R3 wrap literal", ea_out, 32'h0000_0002);

        idle("R9 idle tail", 1'b0, 32'h0);
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule